// File: doc/BRIEF.md
# CPU Reset Start-Sequence Generator

This block reproduces the bus activity of a small 8-bit processor in the cycles that follow the release of its reset line, ending with the first opcode fetch. On leaving reset it reissues the last bus address, then steps to the next address. It then makes three dummy reads in the stack page at falling offsets from whatever stack-pointer value it held. After that it fetches the two-byte start vector and puts the assembled program counter on the bus.

The stack pointer is not assumed to start at zero. It is sampled at the release edge, and it leaves the sequence three lower, modulo 256. Every cycle is a read. The block is meant for models and bus-accurate replicas where a peripheral reacts to the dummy stack reads, for example a memory mapper that switches on stack-page accesses.

Top module: `cpu_start_seq`

## Requirements
- R1: While `rst` is sampled high, the registered outputs read `addr_o`=0, `pc_o`=0, `done_o`=0 and `rd_o`=1.
- R2: The first clock edge with `rst` low starts cycle 1, whose address is `prev_addr_i` as sampled at that edge. Cycle 2 outputs that address plus one, modulo 2^16.
- R3: Cycles 3, 4 and 5 output {8'h01, S}, {8'h01, S-1} and {8'h01, S-2}. S is `sp_i` sampled at the release edge, it may take any value, and the low byte wraps modulo 256.
- R4: From cycle 6 until the next reset, `sp_o` equals S-3 modulo 256.
- R5: Cycle 6 outputs 16'hFFFC and cycle 7 outputs 16'hFFFD. `data_i` is captured as the low vector byte on the edge that ends cycle 6, and as the high byte on the edge that ends cycle 7. From cycle 8 `pc_o` is {high, low}. `data_i` has no effect in any other cycle.
- R6: Cycle 8 outputs {high, low} on `addr_o`. After cycle 8 the address holds that value.
- R7: `done_o` is high for exactly one clock, in cycle 8 only.
- R8: `rd_o` is high in every cycle, so no write occurs during the sequence.
- R9: Asserting `rst` at any point aborts the sequence. After release it restarts from cycle 1 with freshly sampled `prev_addr_i` and `sp_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, standing for the asserted CPU reset line |
| sp_i | input | 8 | Stack-pointer value held by the core, sampled at release |
| prev_addr_i | input | 16 | Bus address of the cycle before release |
| data_i | input | 8 | Read data bus |
| addr_o | output | 16 | Address bus |
| rd_o | output | 1 | Read strobe, high for a read |
| pc_o | output | 16 | Assembled program counter |
| sp_o | output | 8 | Current stack pointer |
| done_o | output | 1 | One-clock pulse on the first opcode fetch |

## Verification
The bench uses the default 16-bit address and 8-bit data widths, with the stack page at 8'h01 and the vector at 16'hFFFC. At these widths a full sweep over all 256 start values of the stack pointer is cheap. That sweep covers every wrap of the stack-page low byte and of the final pointer, and pairs each start value with different previous addresses, including 16'hFFFF, and different vector bytes. Reset pulses injected at several cycles within the sequence exercise the abort-and-restart path.

// File: rtl/cpu_start_pkg.sv
package cpu_start_pkg;
  typedef enum logic [3:0] {
    PH_RESET = 4'd0,
    PH_HOLD  = 4'd1,
    PH_NEXT  = 4'd2,
    PH_STK0  = 4'd3,
    PH_STK1  = 4'd4,
    PH_STK2  = 4'd5,
    PH_VLO   = 4'd6,
    PH_VHI   = 4'd7,
    PH_FETCH = 4'd8,
    PH_RUN   = 4'd9
  } phase_t;
endpackage

// File: rtl/start_phase_seq.sv
module start_phase_seq
  import cpu_start_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase_q,
  output phase_t phase_nxt
);
  always_comb begin
    if (rst) begin
      phase_nxt = PH_RESET;
    end else begin
      unique case (phase_q)
        PH_RESET: phase_nxt = PH_HOLD;
        PH_HOLD:  phase_nxt = PH_NEXT;
        PH_NEXT:  phase_nxt = PH_STK0;
        PH_STK0:  phase_nxt = PH_STK1;
        PH_STK1:  phase_nxt = PH_STK2;
        PH_STK2:  phase_nxt = PH_VLO;
        PH_VLO:   phase_nxt = PH_VHI;
        PH_VHI:   phase_nxt = PH_FETCH;
        PH_FETCH: phase_nxt = PH_RUN;
        default:  phase_nxt = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase_q <= phase_nxt;
  end

  // R7: the fetch phase lasts a single cycle
  p_fetch_once_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FETCH) |=> (phase_q == PH_RUN));
endmodule

// File: rtl/start_vec_latch.sv
module start_vec_latch
  import cpu_start_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase_q,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (phase_q == PH_VLO) lo_q <= data_i;
      if (phase_q == PH_VHI) hi_q <= data_i;
    end
  end

  // R5: the low byte is frozen once the high-byte cycle has passed
  p_lo_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FETCH) |=> $stable(lo_q));
endmodule

// File: rtl/start_addr_gen.sv
module start_addr_gen
  import cpu_start_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              ADDR_W     = 2 * DATA_W,
  parameter logic [DATA_W-1:0] STACK_HI = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase_q,
  input  phase_t            phase_nxt,
  input  logic [ADDR_W-1:0] prev_addr_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] lo_q,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] sp_q
);
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_ADDR + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      sp_q   <= sp_i;
    end else begin
      unique case (phase_nxt)
        PH_HOLD: begin
          addr_q <= prev_addr_i;
          sp_q   <= sp_i;
        end
        PH_NEXT:  addr_q <= addr_q + 1'b1;
        PH_STK0, PH_STK1, PH_STK2: begin
          addr_q <= {STACK_HI, sp_q};
          sp_q   <= sp_q - 1'b1;
        end
        PH_VLO:   addr_q <= VEC_ADDR;
        PH_VHI:   addr_q <= VEC_HI_ADDR;
        PH_FETCH: addr_q <= {data_i, lo_q};
        default:  addr_q <= addr_q;
      endcase
    end
  end

  // R2: cycle 2 steps the held address by one
  p_next_step_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_NEXT) |-> (addr_q == $past(addr_q) + 1'b1));
  // R3: later stack reads descend by one inside the stack page
  p_stack_desc_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_STK1 || phase_q == PH_STK2) |->
      (addr_q[DATA_W-1:0] == $past(addr_q[DATA_W-1:0]) - 1'b1) &&
      (addr_q[ADDR_W-1:DATA_W] == STACK_HI));
  // R5: high vector byte address follows the low one
  p_vec_step_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_VHI) |-> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/cpu_start_seq.sv
module cpu_start_seq
  import cpu_start_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 2 * DATA_W,
  parameter logic [DATA_W-1:0] STACK_HI = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] prev_addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              done_o
);
  phase_t            phase_q;
  phase_t            phase_nxt;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] hi_q;
  logic              done_q;
  logic              rd_q;

  start_phase_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt)
  );

  start_vec_latch #(.DATA_W(DATA_W)) u_vec (
    .clk     (clk),
    .rst     (rst),
    .phase_q (phase_q),
    .data_i  (data_i),
    .lo_q    (lo_q),
    .hi_q    (hi_q)
  );

  start_addr_gen #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .STACK_HI (STACK_HI),
    .VEC_ADDR (VEC_ADDR)
  ) u_addr (
    .clk         (clk),
    .rst         (rst),
    .phase_q     (phase_q),
    .phase_nxt   (phase_nxt),
    .prev_addr_i (prev_addr_i),
    .sp_i        (sp_i),
    .lo_q        (lo_q),
    .data_i      (data_i),
    .addr_q      (addr_o),
    .sp_q        (sp_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      rd_q   <= 1'b1;
    end else begin
      done_q <= (phase_nxt == PH_FETCH);
      rd_q   <= 1'b1;
    end
  end

  assign done_o = done_q;
  assign rd_o   = rd_q;
  assign pc_o   = {hi_q, lo_q};

  // R6: the fetch address equals the assembled program counter
  p_fetch_pc_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (addr_o == pc_o));
  // R7: done never lasts two cycles
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R4: after the last stack read the pointer sits one below it
  p_sp_final_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_VLO) |-> (sp_o == $past(addr_o[DATA_W-1:0]) - 1'b1));
endmodule

// File: tb/cpu_start_seq_tb.sv
module cpu_start_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sp_i = '0;
  logic [15:0] prev_addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [15:0] addr_o;
  logic        rd_o;
  logic [15:0] pc_o;
  logic [7:0]  sp_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cpu_start_seq u_dut (
    .clk(clk), .rst(rst), .sp_i(sp_i), .prev_addr_i(prev_addr_i),
    .data_i(data_i), .addr_o(addr_o), .rd_o(rd_o), .pc_o(pc_o),
    .sp_o(sp_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  // R1 reset-state checks
  task automatic chk_reset;
    chk("R1", "addr in reset", {16'h0, addr_o}, 32'h0);
    chk("R1", "pc in reset", {16'h0, pc_o}, 32'h0);
    chk("R1", "done in reset", {31'h0, done_o}, 32'h0);
    chk("R1", "rd in reset", {31'h0, rd_o}, 32'h1);
  endtask

  // Full sequence from the reset state; garbage on data outside the vector cycles
  task automatic run_seq(input logic [7:0] s, input logic [15:0] prev,
                         input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] expa [1:8];
    logic [7:0]  sm1, sm2, sm3;
    sm1 = s - 8'd1; sm2 = s - 8'd2; sm3 = s - 8'd3;
    expa[1] = prev;
    expa[2] = prev + 16'd1;
    expa[3] = {8'h01, s};
    expa[4] = {8'h01, sm1};
    expa[5] = {8'h01, sm2};
    expa[6] = 16'hFFFC;
    expa[7] = 16'hFFFD;
    expa[8] = {hi, lo};
    rst = 1'b0; sp_i = s; prev_addr_i = prev; data_i = ~lo;
    for (int c = 1; c <= 8; c++) begin
      step();
      sp_i = ~s; prev_addr_i = ~prev;
      data_i = (c == 6) ? lo : (c == 7) ? hi : (8'hA5 ^ 8'(c));
      case (c)
        1: chk("R2", "cycle1 addr", {16'h0, addr_o}, {16'h0, expa[c]});
        2: chk("R2", "cycle2 addr", {16'h0, addr_o}, {16'h0, expa[c]});
        3, 4, 5: chk("R3", "stack addr", {16'h0, addr_o}, {16'h0, expa[c]});
        6, 7: chk("R5", "vector addr", {16'h0, addr_o}, {16'h0, expa[c]});
        default: chk("R6", "fetch addr", {16'h0, addr_o}, {16'h0, expa[c]});
      endcase
      chk("R8", "read strobe", {31'h0, rd_o}, 32'h1);
      chk("R7", "done", {31'h0, done_o}, {31'h0, (c == 8)});
      if (c >= 6) chk("R4", "final sp", {24'h0, sp_o}, {24'h0, sm3});
    end
    chk("R5", "pc", {16'h0, pc_o}, {16'h0, hi, lo});
    step();
    chk("R7", "done after fetch", {31'h0, done_o}, 32'h0);
    chk("R6", "addr holds", {16'h0, addr_o}, {16'h0, hi, lo});
    chk("R5", "pc ignores data", {16'h0, pc_o}, {16'h0, hi, lo});
  endtask

  initial begin
    @(negedge clk);
    step();
    chk_reset();
    for (int s = 0; s < 256; s++) begin
      rst = 1'b1;
      step();
      chk_reset();
      run_seq(8'(s), (s == 255) ? 16'hFFFF : 16'(s * 16'd257 ^ 16'h3C00),
              8'(s) ^ 8'h5A, ~8'(s));
    end
    // R9: abort at each cycle, then full restart
    for (int k = 1; k <= 8; k++) begin
      rst = 1'b1;
      step();
      rst = 1'b0; sp_i = 8'h10; prev_addr_i = 16'h1234;
      for (int c = 0; c < k; c++) step();
      rst = 1'b1;
      step();
      chk("R9", "abort addr", {16'h0, addr_o}, 32'h0);
      chk("R9", "abort done", {31'h0, done_o}, 32'h0);
      run_seq(8'(k * 3), 16'h8000 + 16'(k), 8'h20 + 8'(k), 8'hF0);
    end
    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule